// File: doc/BRIEF.md
# SPI Flash Program and Erase Sequencer

This block drives an SPI flash command engine so that a byte buffer is programmed into flash, or a sector is erased, with no processor involvement. A start request supplies the operation, a 24-bit flash offset and a byte count. For programming, the data arrive on a byte stream with a valid/ready handshake. The sequencer splits the buffer into chunks, and each chunk ends at or before the next 256-byte page boundary. Every chunk and every erase is preceded by a write-enable command and a status read that must show the flash ready. After each program or erase command the sequencer polls status until the flash finishes.

Each step is issued to the engine as one command. The command carries an opcode word, a data word, a transmit byte count and a receive byte count, plus a flag that keeps chip select asserted across several commands. Word mode programs at most 4 bytes per chunk and skips chunks whose data word is all ones. Page mode programs up to 256 bytes per chunk. It sends the first 4 bytes with the program command and each later byte as a single-byte command, with chip select held low the whole time.

Top module: `flash_seq_top`

## Requirements
- R1: Before each program chunk and before an erase, the sequencer issues write enable (opcode word 0x00000006, transmit 1, receive 0), then a status read (opcode word 0x00000005, transmit 1, receive 1).
- R2: If the status bits [1:0] returned for that read are not 2'b10, the sequencer waits at least 800 clock cycles (20 us at 40 clocks per us). It then repeats write enable and the status read, and keeps doing so until the bits read 2'b10.
- R3: A chunk holds at most 4 bytes in word mode (page_mode_i=0) and at most 256 bytes in page mode. When fewer bytes remain than this limit, the chunk holds all of them.
- R4: A chunk is shortened so that offset plus chunk length never passes the next multiple of 256.
- R5: In word mode, a chunk whose packed data word equals 0xFFFFFFFF is not programmed, but offset and remaining length still advance past it. A shorter chunk of 0xFF bytes packs with zero upper bytes and is programmed. Page mode never skips.
- R6: A program command has opcode word {offset[23:0], 8'h02}. Its data word holds the first up to 4 chunk bytes little-endian (first byte in bits [7:0], unused bytes zero). Its transmit count is that byte count plus 4 and its receive count is 0.
- R7: In page mode, chunk bytes after the first 4 are sent one per command: opcode word {24'h0, byte}, transmit 1, receive 0. cmd_cs_hold_o is 1 from the program command through the last such byte, and 0 otherwise.
- R8: After each program or erase command, the sequencer repeats the status read until status bit 0 (busy) is 0. Only then does it advance to the next chunk or finish.
- R9: An erase issues one command with opcode word {offset[23:0], 8'hD8}, transmit 4 and receive 0.
- R10: busy_o is 1 from the cycle after an accepted start until the operation ends. done_o is a one-cycle pulse in the final cycle of the operation. A program of length 0 pulses done_o without issuing any command.
- R11: cmd_req_o is a one-cycle pulse. The next one comes only after cmd_done_i has answered the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken when idle |
| erase_i | input | 1 | 1 = sector erase, 0 = program |
| page_mode_i | input | 1 | 1 = page chunks up to 256 bytes, 0 = word chunks up to 4 |
| offset_i | input | 24 | Flash byte offset |
| length_i | input | 16 | Bytes to program |
| byte_valid_i | input | 1 | Source byte available |
| byte_i | input | 8 | Source byte |
| byte_ready_o | output | 1 | Sequencer takes byte_i this cycle when valid |
| cmd_req_o | output | 1 | One-cycle command request to the engine |
| cmd_opcode_o | output | 32 | Opcode word |
| cmd_wdata_o | output | 32 | Data word for a program command |
| cmd_tx_len_o | output | 4 | Bytes to transmit |
| cmd_rx_len_o | output | 3 | Bytes to receive |
| cmd_cs_hold_o | output | 1 | Keep chip select asserted across commands |
| cmd_done_i | input | 1 | Engine finished the pending command |
| cmd_status_i | input | 2 | Received status bits [1:0], valid with cmd_done_i |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Operation complete pulse |

## Verification
The bench checks word-mode chunks that start two bytes below a page boundary. A sequencer without clipping would emit one 4-byte command that wraps inside the page. It also runs an all-ones word chunk followed by a 3-byte all-ones remainder. A design comparing the wrong width would either skip both chunks or program both. The flash model rejects write enable twice, so a sequencer that skipped the retry, or that shortened the 800-cycle wait, would program too early or show too small a gap. Page-mode transfers that cross a boundary check the single-byte tail, the chip-select hold and the restart at the new page. Erase with several busy polls, and a zero-length program, check the completion handshake.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_WRSR, S_WAIT, S_FILL, S_PROG,
    S_BGET, S_BSEND, S_POLL, S_ADV, S_ERASE, S_FINISH
  } seq_state_e;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_ERASE = 8'hD8;

  localparam logic [1:0] ST_READY = 2'b10;
endpackage

// File: rtl/flash_chunk_plan.sv
module flash_chunk_plan #(
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 256,
  parameter int WORD_BYTES = 4,
  localparam int PAGE_W    = $clog2(PAGE_BYTES),
  localparam int CHUNK_W   = PAGE_W + 1,
  localparam int FIRST_W   = $clog2(WORD_BYTES) + 1
) (
  input  logic [PAGE_W-1:0]  offset_lo_i,
  input  logic [LEN_W-1:0]   remain_i,
  input  logic               page_mode_i,
  output logic [CHUNK_W-1:0] chunk_o,
  output logic [FIRST_W-1:0] first_o,
  output logic [CHUNK_W-1:0] tail_o
);
  localparam int WW = ((LEN_W > CHUNK_W) ? LEN_W : CHUNK_W) + 1;

  logic [WW-1:0] cap_w, rem_w, room_w, lim_w, ch_w, first_w;

  always_comb begin
    cap_w   = page_mode_i ? WW'(PAGE_BYTES) : WW'(WORD_BYTES);
    rem_w   = WW'(remain_i);
    room_w  = WW'(PAGE_BYTES) - WW'(offset_lo_i);
    lim_w   = (rem_w < cap_w) ? rem_w : cap_w;
    ch_w    = (lim_w < room_w) ? lim_w : room_w;
    first_w = (ch_w < WW'(WORD_BYTES)) ? ch_w : WW'(WORD_BYTES);
  end

  assign chunk_o = CHUNK_W'(ch_w);
  assign first_o = FIRST_W'(first_w);
  assign tail_o  = CHUNK_W'(ch_w - first_w);
endmodule

// File: rtl/flash_byte_pack.sv
module flash_byte_pack #(
  parameter int WORD_BYTES = 4,
  localparam int FIRST_W   = $clog2(WORD_BYTES) + 1,
  localparam int WORD_W    = 8 * WORD_BYTES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clear_i,
  input  logic               take_i,
  input  logic [7:0]         byte_i,
  output logic [WORD_W-1:0]  word_o,
  output logic [FIRST_W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      count_o <= '0;
    end else if (clear_i) begin
      word_o  <= '0;
      count_o <= '0;
    end else if (take_i) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
        if (count_o == FIRST_W'(b)) word_o[8*b +: 8] <= byte_i;
      end
      count_o <= count_o + 1'b1;
    end
  end

  p_pack_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> (count_o < FIRST_W'(WORD_BYTES)));
endmodule

// File: rtl/flash_retry_timer.sv
module flash_retry_timer #(
  parameter int DELAY = 800,
  localparam int CNT_W = $clog2(DELAY + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic en_i,
  output logic expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= CNT_W'(DELAY - 1);
    else if (en_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_wait_starts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !expired_o);
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import flash_seq_pkg::*;
#(
  parameter int OFFS_W      = 24,
  parameter int LEN_W       = 16,
  parameter int PAGE_BYTES  = 256,
  parameter int WORD_BYTES  = 4,
  parameter int CLKS_PER_US = 40,
  parameter int RETRY_US    = 20,
  localparam int PAGE_W     = $clog2(PAGE_BYTES),
  localparam int CHUNK_W    = PAGE_W + 1,
  localparam int FIRST_W    = $clog2(WORD_BYTES) + 1,
  localparam int WORD_W     = 8 * WORD_BYTES,
  localparam int OPW_W      = OFFS_W + 8,
  localparam int HDR_BYTES  = OFFS_W / 8 + 1,
  localparam int TX_W       = $clog2(WORD_BYTES + HDR_BYTES + 2),
  localparam int DELAY      = CLKS_PER_US * RETRY_US
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              erase_i,
  input  logic              page_mode_i,
  input  logic [OFFS_W-1:0] offset_i,
  input  logic [LEN_W-1:0]  length_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              byte_ready_o,
  output logic              cmd_req_o,
  output logic [OPW_W-1:0]  cmd_opcode_o,
  output logic [WORD_W-1:0] cmd_wdata_o,
  output logic [TX_W-1:0]   cmd_tx_len_o,
  output logic [2:0]        cmd_rx_len_o,
  output logic              cmd_cs_hold_o,
  input  logic              cmd_done_i,
  input  logic [1:0]        cmd_status_i,
  output logic              busy_o,
  output logic              done_o
);
  localparam int SUM_W = CHUNK_W + 1;

  seq_state_e state_q;
  logic              waiting_q;
  logic [OFFS_W-1:0] offset_q;
  logic [LEN_W-1:0]  remain_q;
  logic              page_q, erase_q;
  logic [CHUNK_W-1:0] chunk_q, tail_q;
  logic [FIRST_W-1:0] first_q;
  logic [7:0]        byte_q;

  logic [CHUNK_W-1:0] plan_chunk, plan_tail;
  logic [FIRST_W-1:0] plan_first;
  logic [WORD_W-1:0]  pack_word;
  logic [FIRST_W-1:0] pack_cnt;
  logic got, status_ok, pack_clear, pack_take, timer_load, timer_exp, is_cmd;

  assign got       = cmd_done_i && waiting_q;
  assign status_ok = (cmd_status_i == ST_READY);

  flash_chunk_plan #(
    .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_plan (
    .offset_lo_i (offset_q[PAGE_W-1:0]),
    .remain_i    (remain_q),
    .page_mode_i (page_q),
    .chunk_o     (plan_chunk),
    .first_o     (plan_first),
    .tail_o      (plan_tail)
  );

  assign pack_clear = (state_q == S_WRSR) && got;
  assign pack_take  = (state_q == S_FILL) && byte_valid_i && (pack_cnt < first_q);

  flash_byte_pack #(.WORD_BYTES(WORD_BYTES)) u_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (pack_clear),
    .take_i  (pack_take),
    .byte_i  (byte_i),
    .word_o  (pack_word),
    .count_o (pack_cnt)
  );

  assign timer_load = (state_q == S_WRSR) && got && !status_ok;

  flash_retry_timer #(.DELAY(DELAY)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (timer_load),
    .en_i      (state_q == S_WAIT),
    .expired_o (timer_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      waiting_q <= 1'b0;
      offset_q  <= '0;
      remain_q  <= '0;
      page_q    <= 1'b0;
      erase_q   <= 1'b0;
      chunk_q   <= '0;
      first_q   <= '0;
      tail_q    <= '0;
      byte_q    <= '0;
    end else begin
      if (cmd_req_o)       waiting_q <= 1'b1;
      else if (cmd_done_i) waiting_q <= 1'b0;

      unique case (state_q)
        S_IDLE: if (start_i) begin
          offset_q <= offset_i;
          remain_q <= length_i;
          page_q   <= page_mode_i;
          erase_q  <= erase_i;
          state_q  <= (erase_i || length_i != '0) ? S_WREN : S_FINISH;
        end
        S_WREN: if (got) state_q <= S_WRSR;
        S_WRSR: if (got) begin
          if (!status_ok)   state_q <= S_WAIT;
          else if (erase_q) state_q <= S_ERASE;
          else begin
            chunk_q <= plan_chunk;
            first_q <= plan_first;
            tail_q  <= plan_tail;
            state_q <= S_FILL;
          end
        end
        S_WAIT: if (timer_exp) state_q <= S_WREN;
        S_FILL: if (pack_cnt == first_q) begin
          // word mode: an erased-state word needs no programming
          if (!page_q && first_q == FIRST_W'(WORD_BYTES) && (&pack_word)) state_q <= S_ADV;
          else                                                            state_q <= S_PROG;
        end
        S_PROG: if (got) state_q <= (tail_q != '0) ? S_BGET : S_POLL;
        S_BGET: if (byte_valid_i) begin
          byte_q  <= byte_i;
          state_q <= S_BSEND;
        end
        S_BSEND: if (got) begin
          tail_q  <= tail_q - 1'b1;
          state_q <= (tail_q == CHUNK_W'(1)) ? S_POLL : S_BGET;
        end
        S_POLL: if (got && !cmd_status_i[0]) state_q <= erase_q ? S_FINISH : S_ADV;
        S_ADV: begin
          offset_q <= offset_q + OFFS_W'(chunk_q);
          remain_q <= remain_q - LEN_W'(chunk_q);
          state_q  <= (remain_q == LEN_W'(chunk_q)) ? S_FINISH : S_WREN;
        end
        S_ERASE:  if (got) state_q <= S_POLL;
        S_FINISH: state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    is_cmd        = 1'b0;
    cmd_opcode_o  = '0;
    cmd_wdata_o   = '0;
    cmd_tx_len_o  = TX_W'(1);
    cmd_rx_len_o  = 3'd0;
    cmd_cs_hold_o = 1'b0;
    unique case (state_q)
      S_WREN: begin
        is_cmd       = 1'b1;
        cmd_opcode_o = OPW_W'(OP_WREN);
      end
      S_WRSR, S_POLL: begin
        is_cmd       = 1'b1;
        cmd_opcode_o = OPW_W'(OP_RDSR);
        cmd_rx_len_o = 3'd1;
      end
      S_PROG: begin
        is_cmd        = 1'b1;
        cmd_opcode_o  = {offset_q, OP_PROG};
        cmd_wdata_o   = pack_word;
        cmd_tx_len_o  = TX_W'(first_q) + TX_W'(HDR_BYTES);
        cmd_cs_hold_o = page_q;
      end
      S_BGET: cmd_cs_hold_o = page_q;
      S_BSEND: begin
        is_cmd        = 1'b1;
        cmd_opcode_o  = OPW_W'(byte_q);
        cmd_cs_hold_o = page_q;
      end
      S_ERASE: begin
        is_cmd       = 1'b1;
        cmd_opcode_o = {offset_q, OP_ERASE};
        cmd_tx_len_o = TX_W'(HDR_BYTES);
      end
      default: ;
    endcase
  end

  assign cmd_req_o    = is_cmd && !waiting_q;
  assign byte_ready_o = (state_q == S_BGET) || ((state_q == S_FILL) && (pack_cnt < first_q));
  assign busy_o       = (state_q != S_IDLE);
  assign done_o       = (state_q == S_FINISH);

  p_req_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |=> !cmd_req_o);
  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cmd_req_o && !byte_ready_o));
  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));
  p_page_fit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && state_q == S_PROG) |->
      (SUM_W'(offset_q[PAGE_W-1:0]) + SUM_W'(chunk_q)) <= SUM_W'(PAGE_BYTES));
  p_word_cap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_req_o && state_q == S_PROG && !page_q) |-> (chunk_q <= CHUNK_W'(WORD_BYTES)));
  p_fill_after_wel_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FILL && $past(state_q) == S_WRSR) |-> ($past(cmd_status_i) == ST_READY));
  p_adv_after_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ADV && $past(state_q) == S_POLL) |-> !$past(cmd_status_i[0]));
endmodule

// File: tb/flash_seq_top_bench.sv
module flash_seq_top_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 0, erase_i = 0, page_mode_i = 0;
  logic [23:0] offset_i = '0;
  logic [15:0] length_i = '0;
  logic byte_valid_i, byte_ready_o;
  logic [7:0] byte_i;
  logic cmd_req_o, cmd_cs_hold_o, cmd_done_i = 0, busy_o, done_o;
  logic [31:0] cmd_opcode_o, cmd_wdata_o;
  logic [3:0] cmd_tx_len_o;
  logic [2:0] cmd_rx_len_o;
  logic [1:0] cmd_status_i = '0;

  always #2 clk_i = ~clk_i;

  flash_seq_top u_flash_seq_top (.*);

  int checks = 0, errors = 0;
  logic [7:0] src [0:511];
  int src_len = 0, src_idx = 0;
  assign byte_valid_i = src_idx < src_len;
  assign byte_i = src[src_idx];

  logic [31:0] l_op [0:511];
  logic [31:0] l_wd [0:511];
  int l_tx [0:511], l_rx [0:511], l_cs [0:511], l_cyc [0:511], l_done [0:511];
  int log_n = 0, pend = 0, countdown = 0, cyc = 0;
  int wel_fail = 0, wip_cfg = 0, wip_left = 0;
  logic [31:0] last_op = '0;
  logic [1:0] rsp;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    cmd_done_i <= 1'b0;
    if (byte_valid_i && byte_ready_o) src_idx <= src_idx + 1;
    if (cmd_req_o) begin
      l_op[log_n] = cmd_opcode_o; l_wd[log_n] = cmd_wdata_o;
      l_tx[log_n] = cmd_tx_len_o; l_rx[log_n] = cmd_rx_len_o;
      l_cs[log_n] = cmd_cs_hold_o; l_cyc[log_n] = cyc;
      pend = log_n; log_n++; countdown = 2;
      if (cmd_opcode_o == 32'h05) begin
        if (last_op == 32'h06) begin
          if (wel_fail > 0) begin wel_fail--; rsp = 2'b00; end else rsp = 2'b10;
        end else begin
          if (wip_left > 0) begin wip_left--; rsp = 2'b01; end else rsp = 2'b00;
        end
      end else rsp = 2'b00;
      if (cmd_opcode_o[7:0] == 8'h02 || cmd_opcode_o[7:0] == 8'hD8) wip_left = wip_cfg;
      last_op = cmd_opcode_o;
    end else if (countdown > 0) begin
      countdown--;
      if (countdown == 0) begin
        cmd_done_i <= 1'b1;
        cmd_status_i <= rsp;
        l_done[pend] = cyc + 1;
      end
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_cmd(int i, logic [31:0] op, int tx, int rx, string req);
    check(l_op[i] == op, req, $sformatf("cmd%0d opcode", i), l_op[i], op);
    check(l_tx[i] == tx, req, $sformatf("cmd%0d tx", i), l_tx[i], tx);
    check(l_rx[i] == rx, req, $sformatf("cmd%0d rx", i), l_rx[i], rx);
  endtask

  task automatic chk_prologue(int i, string req);
    chk_cmd(i, 32'h06, 1, 0, req);
    chk_cmd(i + 1, 32'h05, 1, 1, req);
  endtask

  task automatic run_op(bit er, bit pg, logic [23:0] off, int len);
    int busy_drop = 0, dones = 0, guard = 0;
    log_n = 0; src_idx = 0; src_len = len; last_op = '0;
    @(negedge clk_i);
    start_i = 1; erase_i = er; page_mode_i = pg; offset_i = off; length_i = 16'(len);
    @(negedge clk_i);
    start_i = 0;
    while (!done_o && guard < 20000) begin
      if (!busy_o) busy_drop++;
      @(negedge clk_i);
      guard++;
    end
    if (done_o) dones++;
    check(busy_o == 1'b1, "R10", "busy with done", busy_o, 1);
    @(negedge clk_i);
    if (done_o) dones++;
    check(dones == 1, "R10", "done pulses", dones, 1);
    check(busy_drop == 0, "R10", "busy drops", busy_drop, 0);
    check(busy_o == 1'b0, "R10", "busy after done", busy_o, 0);
  endtask

  task automatic t_reset;
    check(busy_o == 0 && done_o == 0, "R10", "reset busy/done", {busy_o, done_o}, 0);
    check(cmd_req_o == 0 && byte_ready_o == 0, "R11", "reset req/ready", {cmd_req_o, byte_ready_o}, 0);
  endtask

  task automatic t_word_basic;
    for (int i = 0; i < 8; i++) src[i] = 8'(8'h11 + i);
    wip_cfg = 0;
    run_op(0, 0, 24'h000010, 8);
    check(log_n == 8, "R3", "word cmd count", log_n, 8);
    chk_prologue(0, "R1");
    chk_cmd(2, 32'h00001002, 8, 0, "R6");
    check(l_wd[2] == 32'h14131211, "R6", "word data 0", l_wd[2], 32'h14131211);
    chk_cmd(3, 32'h05, 1, 1, "R8");
    chk_prologue(4, "R1");
    chk_cmd(6, 32'h00001402, 8, 0, "R6");
    check(l_wd[6] == 32'h18171615, "R6", "word data 1", l_wd[6], 32'h18171615);
    check(l_cs[2] == 0, "R7", "no cs hold in word mode", l_cs[2], 0);
  endtask

  task automatic t_word_boundary;
    for (int i = 0; i < 6; i++) src[i] = 8'(8'hA0 + i);
    run_op(0, 0, 24'h0000FE, 6);
    check(log_n == 8, "R4", "boundary cmd count", log_n, 8);
    chk_cmd(2, 32'h0000FE02, 6, 0, "R4");
    check(l_wd[2] == 32'h0000A1A0, "R6", "clipped data", l_wd[2], 32'h0000A1A0);
    chk_cmd(6, 32'h00010002, 8, 0, "R4");
    check(l_wd[6] == 32'hA5A4A3A2, "R6", "next page data", l_wd[6], 32'hA5A4A3A2);
  endtask

  task automatic t_ff_skip;
    for (int i = 0; i < 7; i++) src[i] = 8'hFF;
    run_op(0, 0, 24'h000040, 7);
    check(log_n == 6, "R5", "skip cmd count", log_n, 6);
    chk_prologue(0, "R5");
    chk_prologue(2, "R5");
    chk_cmd(4, 32'h00004402, 7, 0, "R5");
    check(l_wd[4] == 32'h00FFFFFF, "R5", "short ff data", l_wd[4], 32'h00FFFFFF);
  endtask

  task automatic t_retry;
    src[0] = 8'h5A; src[1] = 8'hC3;
    wel_fail = 2;
    run_op(0, 0, 24'h000200, 2);
    check(log_n == 8, "R2", "retry cmd count", log_n, 8);
    chk_prologue(0, "R2"); chk_prologue(2, "R2"); chk_prologue(4, "R2");
    chk_cmd(6, 32'h00020002, 6, 0, "R2");
    check(l_wd[6] == 32'h0000C35A, "R6", "retry data", l_wd[6], 32'h0000C35A);
    check(l_cyc[2] - l_done[1] >= 800 && l_cyc[2] - l_done[1] <= 802, "R2", "retry gap 1",
          l_cyc[2] - l_done[1], 801);
    check(l_cyc[4] - l_done[3] >= 800 && l_cyc[4] - l_done[3] <= 802, "R2", "retry gap 2",
          l_cyc[4] - l_done[3], 801);
  endtask

  task automatic t_erase_wip;
    wip_cfg = 3;
    run_op(1, 0, 24'h012000, 0);
    check(log_n == 7, "R8", "erase cmd count", log_n, 7);
    chk_prologue(0, "R1");
    chk_cmd(2, 32'h012000D8, 4, 0, "R9");
    for (int i = 3; i < 7; i++) chk_cmd(i, 32'h05, 1, 1, "R8");
    wip_cfg = 0;
  endtask

  task automatic t_page;
    for (int i = 0; i < 20; i++) src[i] = 8'(i + 1);
    run_op(0, 1, 24'h0000F0, 20);
    check(log_n == 20, "R3", "page cmd count", log_n, 20);
    chk_prologue(0, "R1");
    chk_cmd(2, 32'h0000F002, 8, 0, "R6");
    check(l_wd[2] == 32'h04030201, "R6", "page head data", l_wd[2], 32'h04030201);
    for (int i = 3; i < 15; i++) begin
      chk_cmd(i, 32'(i + 2), 1, 0, "R7");
      check(l_cs[i] == 1, "R7", "cs hold tail", l_cs[i], 1);
    end
    check(l_cs[2] == 1, "R7", "cs hold head", l_cs[2], 1);
    check(l_cs[15] == 0, "R7", "cs released at poll", l_cs[15], 0);
    chk_cmd(15, 32'h05, 1, 1, "R8");
    chk_cmd(18, 32'h00010002, 8, 0, "R4");
    check(l_wd[18] == 32'h14131211, "R6", "page second data", l_wd[18], 32'h14131211);
  endtask

  task automatic t_page_ff;
    for (int i = 0; i < 4; i++) src[i] = 8'hFF;
    run_op(0, 1, 24'h000300, 4);
    check(log_n == 4, "R5", "page ff not skipped", log_n, 4);
    chk_cmd(2, 32'h00030002, 8, 0, "R5");
    check(l_wd[2] == 32'hFFFFFFFF, "R5", "page ff data", l_wd[2], 32'hFFFFFFFF);
  endtask

  task automatic t_zero;
    run_op(0, 0, 24'h000500, 0);
    check(log_n == 0, "R10", "zero length cmds", log_n, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_word_basic();
    t_word_boundary();
    t_ff_skip();
    t_retry();
    t_erase_wip();
    t_page();
    t_page_ff();
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule